// File: doc/BRIEF.md
# Ethernet Receive Packet Checker

This block watches the receive side of a high-speed Ethernet MAC during link bring-up and a packet test run. After reset it waits for the transceiver reset sequence to finish. It then enables the receiver and waits for the MAC to report lane alignment. Once aligned, it takes in a fixed number of packets on a beat-based receive bus. Each beat carries a valid strobe, start and end markers, and a count of unused bytes on the closing beat.

Every packet is compared with a generated pattern, and its length is checked. When the frame check sequence is kept on received frames, the last four bytes are also compared with a constant. Any difference raises a fail indicator, which stays set until the restart input is driven. After the run the block can wait for a pause-frame test to finish, and it can accept a short run of timestamp packets. It then waits for a restart pulse before running the test again. Losing alignment in any post-alignment state returns it to idle.

Top module: `eth_rx_pkt_checker`

## Requirements
- R1: After reset the block is idle with every indicator and the receive enable low. It stays idle while `reset_done` is low.
- R2: When `reset_done` is high in idle, the next state is a lock state. In the lock state `lock_ind`, `busy_ind` and `rx_enable` are high. One clock later the block always moves on to wait for alignment.
- R3: The block waits until `mac_aligned` is high. It then spends one clock in an init state with `aligned_ind` and `busy_ind` high and `done_ind` low, and then enters the receive state.
- R4: The expected byte at offset n of a packet is n modulo 256. Offset 0 is the first byte of the start beat, and lane k of a beat is `rx_data[8k+7:8k]`. A differing byte in a used lane of a packet received in the receive state sets `fail_ind` one clock after that packet's end beat.
- R5: Packet length is (beats − 1) × BEAT_BYTES + BEAT_BYTES − `rx_empty`. `rx_empty` counts the unused top lanes of the end beat. A length other than PKT_LEN is a mismatch.
- R6: With KEEP_FCS set, bytes PKT_LEN−4 to PKT_LEN−1 must equal FCS_CONST. The byte at offset PKT_LEN−4 holds bits 7:0. With KEEP_FCS clear, those bytes follow the pattern of R4.
- R7: `fail_ind` stays high until a clock edge at which `restart` is high. A restart clear wins over a new mismatch. Leaving the receive state does not clear it.
- R8: The end beat of packet NUM_PKTS moves the block to a done state with `done_ind` high.
- R9: With FC_EN set, the block holds in the done state (or the timestamp-done state) until `pause_done` is high. Without FC_EN it moves to wait-for-restart on the next clock.
- R10: With TS_EN set, the done state leads to a timestamp state. That state accepts exactly three packets without comparing them, then moves to a timestamp-done state.
- R11: In wait-for-restart, `busy_ind` is low and `aligned_ind` and `done_ind` are high. Only a rising edge of `restart` moves the block to the init state.
- R12: `mac_aligned` low in the init, receive, done, timestamp or wait-for-restart states returns the block to idle at the next clock. `lock_ind` and `rx_enable` are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_done | input | 1 | Transceiver reset sequence finished |
| mac_aligned | input | 1 | MAC receive lanes aligned |
| restart | input | 1 | Restart request; its level clears the fail flag and its rising edge re-arms the run |
| pause_done | input | 1 | Pause-frame test finished |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Beat starts a packet |
| rx_eop | input | 1 | Beat ends a packet |
| rx_empty | input | $clog2(BEAT_BYTES) | Unused top lanes on the end beat |
| rx_data | input | 8*BEAT_BYTES | Beat data, lane 0 in the low byte |
| lock_ind | output | 1 | Transceiver lock indicator |
| busy_ind | output | 1 | Receive test in progress |
| aligned_ind | output | 1 | Alignment seen, run armed |
| fail_ind | output | 1 | Sticky data mismatch flag |
| done_ind | output | 1 | Packet run finished |
| rx_enable | output | 1 | Receive enable towards the MAC |

## Verification
The state and the fail flag are registered, and every indicator is decoded from the state. So each result appears one clock edge after the input that causes it: a control level, the end beat of a packet, or a restart edge. The bench drives inputs on the falling edge. It reads outputs on the next falling edge, after exactly one rising edge has passed, or after a counted number of edges when it checks that the block holds its state. Two configurations run side by side, one with every option set and one with none, and the bench computes the packet bytes arithmetically from the offset.

// File: rtl/eth_rxchk_pkg.sv
// Shared definitions for the receive packet checker: monitor states and
// fixed counts. Assumes nothing beyond a SystemVerilog-2017 compiler.
package eth_rxchk_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOCK,
        ST_WAIT_ALIGN,
        ST_INIT,
        ST_RX,
        ST_DONE,
        ST_TS_RX,
        ST_TS_DONE,
        ST_WAIT_RST
    } mon_state_t;

    localparam int TS_PKTS   = 3;
    localparam int FCS_BYTES = 4;
endpackage

// File: rtl/rxchk_rise_det.sv
// Rising-edge detector for a synchronous level input.
// Assumes din is already synchronous to clk; rise is combinational.
module rxchk_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic din_q;

    // Keep last cycle's level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;

    // R11
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rxchk_beat_cmp.sv
// Per-beat packet comparator. It tracks the byte offset within the current
// packet, compares every used lane with the incrementing pattern (or with
// the FCS constant on the trailing bytes), and on the end beat reports
// whether the packet matched in content and length.
// Assumes packets start with sop; arm low clears all tracking state.
module rxchk_beat_cmp
    import eth_rxchk_pkg::*;
#(
    parameter int          BEAT_BYTES = 64,
    parameter int          PKT_LEN    = 522,
    parameter bit          KEEP_FCS   = 1'b0,
    parameter logic [31:0] FCS_CONST  = 32'h0,
    parameter int          OFF_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        arm,
    input  logic                        valid,
    input  logic                        sop,
    input  logic                        eop,
    input  logic [$clog2(BEAT_BYTES)-1:0] empty,
    input  logic [8*BEAT_BYTES-1:0]     data,
    output logic                        pkt_end,
    output logic                        pkt_bad
);
    localparam logic [OFF_W-1:0] FCS_START = OFF_W'(PKT_LEN - FCS_BYTES);
    localparam logic [OFF_W-1:0] LEN_VAL   = OFF_W'(PKT_LEN);
    localparam logic [OFF_W-1:0] BEAT_VAL  = OFF_W'(BEAT_BYTES);

    logic [OFF_W-1:0]      off_q;
    logic                  err_q;
    logic [OFF_W-1:0]      base;
    logic [BEAT_BYTES-1:0] lane_err;
    logic [OFF_W-1:0]      beat_len;
    logic                  err_acc;

    // Offset of lane 0 in this beat: zero on a start beat.
    assign base = sop ? '0 : off_q;

    for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
        logic [OFF_W-1:0] boff;
        logic [7:0]       exp_b;
        logic             used;
        logic [OFF_W-1:0] fidx;
        assign boff = base + OFF_W'(i);
        assign fidx = boff - FCS_START;
        // Choose expected byte: FCS constant on trailing bytes, pattern elsewhere.
        always_comb begin
            if (KEEP_FCS && boff >= FCS_START && boff < LEN_VAL)
                exp_b = 8'(FCS_CONST >> (8 * fidx[1:0]));
            else
                exp_b = boff[7:0];
        end
        assign used        = !eop || (i < BEAT_BYTES - int'(empty));
        assign lane_err[i] = valid && used && (data[8*i +: 8] != exp_b);
    end

    assign beat_len = base + BEAT_VAL - OFF_W'(empty);
    assign err_acc  = (sop ? 1'b0 : err_q) | (|lane_err);
    assign pkt_end  = arm & valid & eop;
    assign pkt_bad  = err_acc | (beat_len != LEN_VAL);

    // Advance offset and accumulate lane errors per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            off_q <= '0;
            err_q <= 1'b0;
        end else if (valid) begin
            off_q <= base + BEAT_VAL;
            err_q <= err_acc;
        end
    end

    // R4
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && valid && sop && !(|lane_err)) |=> !err_q);
endmodule

// File: rtl/rxchk_seq.sv
// Bring-up and run sequencer for the receive checker. Steps from idle
// through lock and alignment, counts packets, takes the optional pause and
// timestamp branches, and holds the sticky fail flag.
// Assumes pkt_end is a single-cycle strobe per packet end beat.
module rxchk_seq
    import eth_rxchk_pkg::*;
#(
    parameter int NUM_PKTS = 16,
    parameter bit FC_EN    = 1'b0,
    parameter bit TS_EN    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_done,
    input  logic aligned,
    input  logic restart,
    input  logic restart_rise,
    input  logic pause_done,
    input  logic pkt_end,
    input  logic pkt_bad,
    output logic arm,
    output logic lock_ind,
    output logic busy_ind,
    output logic aligned_ind,
    output logic fail_ind,
    output logic done_ind
);
    localparam int MAX_CNT = (NUM_PKTS > TS_PKTS) ? NUM_PKTS : TS_PKTS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(NUM_PKTS - 1);
    localparam logic [CNT_W-1:0] LAST_TS = CNT_W'(TS_PKTS - 1);

    mon_state_t       state, nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             fail_q;
    logic             post_align;

    assign post_align = state inside {ST_INIT, ST_RX, ST_DONE, ST_TS_RX,
                                      ST_TS_DONE, ST_WAIT_RST};

    // Next-state selection, with alignment loss overriding everything.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (reset_done) nxt = ST_LOCK;
            ST_LOCK:       nxt = ST_WAIT_ALIGN;
            ST_WAIT_ALIGN: if (aligned) nxt = ST_INIT;
            ST_INIT:       nxt = ST_RX;
            ST_RX:         if (pkt_end && cnt_q == LAST_RX) nxt = ST_DONE;
            ST_DONE: begin
                if (TS_EN)                    nxt = ST_TS_RX;
                else if (!FC_EN || pause_done) nxt = ST_WAIT_RST;
            end
            ST_TS_RX:      if (pkt_end && cnt_q == LAST_TS) nxt = ST_TS_DONE;
            ST_TS_DONE:    if (!FC_EN || pause_done) nxt = ST_WAIT_RST;
            ST_WAIT_RST:   if (restart_rise) nxt = ST_INIT;
            default:       nxt = ST_IDLE;
        endcase
        if (post_align && !aligned) nxt = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Packet counter: runs only in the two receiving states.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm)  cnt_q <= '0;
        else if (pkt_end)    cnt_q <= cnt_q + 1'b1;
    end

    // Sticky fail flag; restart level clears and wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fail_q <= 1'b0;
        else if (restart)                             fail_q <= 1'b0;
        else if (state == ST_RX && pkt_end && pkt_bad) fail_q <= 1'b1;
    end

    assign arm         = (state == ST_RX) || (state == ST_TS_RX);
    assign lock_ind    = (state != ST_IDLE);
    assign busy_ind    = (state != ST_IDLE) && (state != ST_WAIT_RST);
    assign aligned_ind = post_align;
    assign done_ind    = state inside {ST_DONE, ST_TS_RX, ST_TS_DONE, ST_WAIT_RST};
    assign fail_ind    = fail_q;

    // R12
    align_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_align && !aligned) |=> state == ST_IDLE);
    // R7
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !restart) |=> fail_q);
    // R2
    lock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOCK |=> state == ST_WAIT_ALIGN);
    // R11
    rst_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RST && aligned && !restart_rise) |=> state == ST_WAIT_RST);
    // R10
    ts_nofail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TS_RX && !fail_q) |=> !fail_q);
    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAX_CNT);
endmodule

// File: rtl/eth_rx_pkt_checker.sv
// Top of the receive packet checker: joins the restart edge detector, the
// beat comparator and the run sequencer. Assumes all inputs are synchronous
// to clk; receive enable follows the lock indication.
module eth_rx_pkt_checker #(
    parameter int          BEAT_BYTES = 64,
    parameter int          PKT_LEN    = 522,
    parameter int          NUM_PKTS   = 16,
    parameter bit          FC_EN      = 1'b0,
    parameter bit          TS_EN      = 1'b0,
    parameter bit          KEEP_FCS   = 1'b0,
    parameter logic [31:0] FCS_CONST  = 32'h0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reset_done,
    input  logic                          mac_aligned,
    input  logic                          restart,
    input  logic                          pause_done,
    input  logic                          rx_valid,
    input  logic                          rx_sop,
    input  logic                          rx_eop,
    input  logic [$clog2(BEAT_BYTES)-1:0] rx_empty,
    input  logic [8*BEAT_BYTES-1:0]       rx_data,
    output logic                          lock_ind,
    output logic                          busy_ind,
    output logic                          aligned_ind,
    output logic                          fail_ind,
    output logic                          done_ind,
    output logic                          rx_enable
);
    localparam int OFF_W = $clog2(2 * PKT_LEN + 2 * BEAT_BYTES);

    logic restart_rise;
    logic arm;
    logic pkt_end;
    logic pkt_bad;

    rxchk_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (restart),
        .rise  (restart_rise)
    );

    rxchk_beat_cmp #(
        .BEAT_BYTES (BEAT_BYTES),
        .PKT_LEN    (PKT_LEN),
        .KEEP_FCS   (KEEP_FCS),
        .FCS_CONST  (FCS_CONST),
        .OFF_W      (OFF_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .valid   (rx_valid),
        .sop     (rx_sop),
        .eop     (rx_eop),
        .empty   (rx_empty),
        .data    (rx_data),
        .pkt_end (pkt_end),
        .pkt_bad (pkt_bad)
    );

    rxchk_seq #(
        .NUM_PKTS (NUM_PKTS),
        .FC_EN    (FC_EN),
        .TS_EN    (TS_EN)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_done   (reset_done),
        .aligned      (mac_aligned),
        .restart      (restart),
        .restart_rise (restart_rise),
        .pause_done   (pause_done),
        .pkt_end      (pkt_end),
        .pkt_bad      (pkt_bad),
        .arm          (arm),
        .lock_ind     (lock_ind),
        .busy_ind     (busy_ind),
        .aligned_ind  (aligned_ind),
        .fail_ind     (fail_ind),
        .done_ind     (done_ind)
    );

    assign rx_enable = lock_ind;
endmodule

// File: tb/tb_eth_rx_pkt_checker.sv
module tb_eth_rx_pkt_checker;
    localparam int          BB  = 8;
    localparam int          PL  = 20;
    localparam int          NP  = 3;
    localparam logic [31:0] FCV = 32'hA1B2C3D4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       rd [2];
    logic       al [2];
    logic       rs [2];
    logic       pd [2];
    logic       v  [2];
    logic       s  [2];
    logic       e  [2];
    logic [2:0] em [2];
    logic [63:0] d [2];
    logic lk [2];
    logic bz [2];
    logic ai [2];
    logic fl [2];
    logic dn [2];
    logic re [2];

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    eth_rx_pkt_checker #(.BEAT_BYTES(BB), .PKT_LEN(PL), .NUM_PKTS(NP),
        .FC_EN(1'b1), .TS_EN(1'b1), .KEEP_FCS(1'b1), .FCS_CONST(FCV)) dut (
        .clk(clk), .rst_n(rst_n), .reset_done(rd[0]), .mac_aligned(al[0]),
        .restart(rs[0]), .pause_done(pd[0]), .rx_valid(v[0]), .rx_sop(s[0]),
        .rx_eop(e[0]), .rx_empty(em[0]), .rx_data(d[0]), .lock_ind(lk[0]),
        .busy_ind(bz[0]), .aligned_ind(ai[0]), .fail_ind(fl[0]),
        .done_ind(dn[0]), .rx_enable(re[0]));

    eth_rx_pkt_checker #(.BEAT_BYTES(BB), .PKT_LEN(PL), .NUM_PKTS(NP),
        .FC_EN(1'b0), .TS_EN(1'b0), .KEEP_FCS(1'b0), .FCS_CONST(FCV)) dut_plain (
        .clk(clk), .rst_n(rst_n), .reset_done(rd[1]), .mac_aligned(al[1]),
        .restart(rs[1]), .pause_done(pd[1]), .rx_valid(v[1]), .rx_sop(s[1]),
        .rx_eop(e[1]), .rx_empty(em[1]), .rx_data(d[1]), .lock_ind(lk[1]),
        .busy_ind(bz[1]), .aligned_ind(ai[1]), .fail_ind(fl[1]),
        .done_ind(dn[1]), .rx_enable(re[1]));

    task automatic tick();
        @(negedge clk);
    endtask

    // Compare all six outputs of unit u against expectations.
    task automatic expect_out(int u, bit l, bit b, bit a, bit f, bit dd, string tag);
        bit [5:0] got;
        bit [5:0] exp;
        got = {lk[u], bz[u], ai[u], fl[u], dn[u], re[u]};
        exp = {l, b, a, f, dd, l};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s unit%0d lock/busy/align/fail/done/en actual=%b expected=%b",
                     tag, u, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int u, int off);
        if (u == 0 && off >= PL - 4 && off < PL)
            return FCV[8*(off-(PL-4)) +: 8];
        return 8'(off);
    endfunction

    // Send one packet of len bytes; the byte at err_at is inverted.
    task automatic send(int u, int len, int err_at);
        int nb;
        nb = (len + BB - 1) / BB;
        for (int b = 0; b < nb; b++) begin
            v[u] = 1'b1;
            s[u] = (b == 0);
            e[u] = (b == nb - 1);
            em[u] = (b == nb - 1) ? 3'(nb * BB - len) : 3'd0;
            for (int i = 0; i < BB; i++) begin
                int off;
                off = b * BB + i;
                d[u][8*i +: 8] = exp_byte(u, off) ^ ((off == err_at) ? 8'hFF : 8'h00);
            end
            tick();
        end
        v[u] = 1'b0; s[u] = 1'b0; e[u] = 1'b0; em[u] = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            rd[u] = 0; al[u] = 0; rs[u] = 0; pd[u] = 0;
            v[u] = 0; s[u] = 0; e[u] = 0; em[u] = '0; d[u] = '0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_out(0, 0, 0, 0, 0, 0, "R1 reset");
        expect_out(1, 0, 0, 0, 0, 0, "R1 reset");
        tick(); tick();
        expect_out(0, 0, 0, 0, 0, 0, "R1 idle held");

        // ---- fully optioned unit ----
        rd[0] = 1; tick();
        expect_out(0, 1, 1, 0, 0, 0, "R2 lock");
        tick();
        expect_out(0, 1, 1, 0, 0, 0, "R2 wait align");
        tick();
        expect_out(0, 1, 1, 0, 0, 0, "R3 still waiting");
        al[0] = 1; tick();
        expect_out(0, 1, 1, 1, 0, 0, "R3 init");
        tick();
        send(0, PL, -1); send(0, PL, -1);
        expect_out(0, 1, 1, 1, 0, 0, "R4 good packets");
        send(0, PL, -1);
        expect_out(0, 1, 1, 1, 0, 1, "R8 done");
        tick();
        expect_out(0, 1, 1, 1, 0, 1, "R10 ts state");
        send(0, PL, 2); send(0, PL, 3); send(0, 12, -1);
        expect_out(0, 1, 1, 1, 0, 1, "R10 ts packets ignored");
        tick(); tick();
        expect_out(0, 1, 1, 1, 0, 1, "R9 pause wait");
        pd[0] = 1; tick(); pd[0] = 0;
        expect_out(0, 1, 0, 1, 0, 1, "R11 wait restart");
        tick(); tick();
        expect_out(0, 1, 0, 1, 0, 1, "R11 holds without edge");
        rs[0] = 1; tick();
        expect_out(0, 1, 1, 1, 0, 0, "R11 restart edge");
        rs[0] = 0; tick();
        send(0, PL, 5);
        expect_out(0, 1, 1, 1, 1, 0, "R4 data mismatch");
        tick(); tick();
        expect_out(0, 1, 1, 1, 1, 0, "R7 sticky");
        rs[0] = 1; tick(); rs[0] = 0;
        expect_out(0, 1, 1, 1, 0, 0, "R7 restart clears");
        send(0, PL - 1, -1);
        expect_out(0, 1, 1, 1, 1, 0, "R5 short length");
        rs[0] = 1; tick(); rs[0] = 0;
        send(0, PL, PL - 3);
        expect_out(0, 1, 1, 1, 1, 1, "R6 fcs mismatch");
        al[0] = 0; tick();
        expect_out(0, 0, 0, 0, 1, 0, "R12 align loss");
        rd[0] = 0;

        // ---- plain unit ----
        al[1] = 1; rd[1] = 1; tick();
        expect_out(1, 1, 1, 0, 0, 0, "R2 lock plain");
        tick(); tick();
        expect_out(1, 1, 1, 1, 0, 0, "R3 init plain");
        tick();
        send(1, PL, -1); send(1, PL, -1); send(1, PL, -1);
        expect_out(1, 1, 1, 1, 0, 1, "R6 pattern tail without fcs");
        tick();
        expect_out(1, 1, 0, 1, 0, 1, "R9 no flow control");
        rs[1] = 1; tick(); rs[1] = 0; tick();
        send(1, PL + 1, -1);
        expect_out(1, 1, 1, 1, 1, 0, "R5 long length");
        al[1] = 0; tick();
        expect_out(1, 0, 0, 0, 1, 0, "R12 align loss plain");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule